// File: doc/BRIEF.md
# PLL Divider Setting Search Engine

This block finds a divider setting for a frequency synthesizer. On a start pulse it captures a reference frequency and a requested output frequency, limits the request to the legal output range, and then steps through every combination of feedback divider, reference divider and the two post-dividers. A combination counts only if its oscillator frequency lies inside the allowed window. Among the counting combinations it keeps the one whose output comes closest to the request without going over it.

The result is a packed 24-bit divider word and the integer output frequency that word produces. If no combination gives a nonzero output, an error flag is raised instead. The search stops as soon as a combination hits the limited request exactly. A single iterative divider is shared across the whole search and runs only when a candidate beats the current best. Every other comparison is an exact integer threshold test built from products.

All frequencies are unsigned integers in one unit, normally hertz. The divider ranges, oscillator window and output range are parameters.

Top module: `pll_div_search`

## Requirements
- R1: After reset, busy_o, done_o and err_o are 0, and setting_o and rate_o are all zeros.
- R2: A start_i pulse while busy_o is 0 captures ref_i and req_i and raises busy_o on the next cycle. A start_i pulse while busy_o is 1 is ignored and leaves the running search and its result unchanged.
- R3: When err_o is 0, rate_o equals floor(ref × fb / (rd × (p1+1) × (p2+1))) for the fields in setting_o, and it never exceeds the limited request.
- R4: The chosen setting gives the largest such rate that does not exceed the limited request. Ties go to the first combination in search order: fb ascending (outermost), then rd ascending, then p2 ascending, then p1 ascending (innermost).
- R5: A feedback/reference divider pair is used only when floor(ref × fb / rd) lies within [VCO_MIN, VCO_MAX] inclusive.
- R6: Before the search, the request is limited to the range [OUT_MIN, OUT_MAX].
- R7: setting_o holds fb in bits 11:0, rd in bits 17:12, p1 in bits 20:18 and p2 in bits 23:21. fb ranges over [FB_MIN, FB_MAX], rd over [RD_MIN, RD_MAX], and p1 and p2 over 0..7.
- R8: When no candidate gives a nonzero rate, err_o is 1 and setting_o and rate_o are zero.
- R9: done_o pulses high for exactly one cycle, in the cycle where busy_o has just fallen. setting_o, rate_o and err_o change only at that point and hold their values while busy_o is 1.
- R10: The search ends as soon as a candidate's rate equals the limited request, so an exact hit finishes in fewer cycles than a full sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a search (used only while idle) |
| ref_i | input | FREQ_W | Reference frequency |
| req_i | input | FREQ_W | Requested output frequency |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| setting_o | output | 24 | Packed divider word |
| rate_o | output | FREQ_W | Output frequency of the chosen setting |
| err_o | output | 1 | No usable setting was found |

## Verification
Each request is compared with an independent reference search in the bench. The request patterns are chosen to tell different faults apart:
- An exact hit, run next to a request one unit lower, separates early exit from a full sweep, both in result and in duration.
- Requests below and above the output range show whether limiting happens.
- A reference so low that no oscillator frequency is legal exposes the error path.
- A reference where only a few pairs pass the window, and a tie-rich sweep, expose faults in the window test and in tie order.
- A second start during a running search checks that the block ignores it.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;
  localparam int FB_W  = 12;
  localparam int RD_W  = 6;
  localparam int PD_W  = 3;
  localparam int SET_W = FB_W + RD_W + 2 * PD_W;

  // field order is the packed word layout: p2 23:21, p1 20:18, rd 17:12, fb 11:0
  typedef struct packed {
    logic [PD_W-1:0] p2;
    logic [PD_W-1:0] p1;
    logic [RD_W-1:0] rd;
    logic [FB_W-1:0] fb;
  } pll_set_t;

  typedef enum logic [2:0] {
    S_IDLE, S_PAIR, S_POST, S_DIV, S_FIN
  } srch_st_e;
endpackage

// File: rtl/pll_cand_iter.sv
module pll_cand_iter
  import pll_srch_pkg::*;
#(
  parameter int FB_MIN = 8,
  parameter int FB_MAX = 1066,
  parameter int RD_MIN = 1,
  parameter int RD_MAX = 63
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     init_i,
  input  logic     next_pair_i,
  input  logic     next_post_i,
  output pll_set_t cand_o,
  output logic     last_pair_o,
  output logic     last_post_o
);
  localparam logic [PD_W-1:0] PD_LAST = {PD_W{1'b1}};

  pll_set_t cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
    end else if (init_i) begin
      cur_q.fb <= FB_W'(FB_MIN);
      cur_q.rd <= RD_W'(RD_MIN);
      cur_q.p1 <= '0;
      cur_q.p2 <= '0;
    end else if (next_pair_i) begin
      cur_q.p1 <= '0;
      cur_q.p2 <= '0;
      if (cur_q.rd == RD_W'(RD_MAX)) begin
        cur_q.rd <= RD_W'(RD_MIN);
        cur_q.fb <= cur_q.fb + 1'b1;
      end else begin
        cur_q.rd <= cur_q.rd + 1'b1;
      end
    end else if (next_post_i) begin
      if (cur_q.p1 == PD_LAST) begin
        cur_q.p1 <= '0;
        cur_q.p2 <= cur_q.p2 + 1'b1;
      end else begin
        cur_q.p1 <= cur_q.p1 + 1'b1;
      end
    end
  end

  assign cand_o      = cur_q;
  assign last_pair_o = (cur_q.fb == FB_W'(FB_MAX)) && (cur_q.rd == RD_W'(RD_MAX));
  assign last_post_o = (cur_q.p1 == PD_LAST) && (cur_q.p2 == PD_LAST);
endmodule

// File: rtl/pll_seq_div.sv
module pll_seq_div #(
  parameter int NW = 76,
  parameter int DW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [NW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  output logic          done_o,
  output logic [NW-1:0] quo_o
);
  localparam int CW = $clog2(NW + 1);

  logic          run_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] den_q;
  logic [DW-1:0] rem_q;
  logic [NW-1:0] num_q;
  logic [DW:0]   trial;
  logic          fits;

  assign trial = {rem_q, num_q[NW-1]};
  assign fits  = trial >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      den_q  <= '0;
      rem_q  <= '0;
      num_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        run_q <= 1'b1;
        cnt_q <= '0;
        den_q <= den_i;
        rem_q <= '0;
        num_q <= num_i;
      end else if (run_q) begin
        rem_q <= fits ? DW'(trial - {1'b0, den_q}) : trial[DW-1:0];
        num_q <= {num_q[NW-2:0], fits};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(NW - 1)) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quo_o = num_q;
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pll_srch_pkg::*;
#(
  parameter int                FREQ_W  = 64,
  parameter int                FB_MIN  = 8,
  parameter int                FB_MAX  = 1066,
  parameter int                RD_MIN  = 1,
  parameter int                RD_MAX  = 63,
  parameter logic [FREQ_W-1:0] VCO_MIN = FREQ_W'(64'd1600000000),
  parameter logic [FREQ_W-1:0] VCO_MAX = FREQ_W'(64'd3200000000),
  parameter logic [FREQ_W-1:0] OUT_MIN = FREQ_W'(64'd25000),
  parameter logic [FREQ_W-1:0] OUT_MAX = FREQ_W'(64'd3200000000)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] ref_i,
  input  logic [FREQ_W-1:0] req_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [SET_W-1:0]  setting_o,
  output logic [FREQ_W-1:0] rate_o,
  output logic              err_o
);
  localparam int PDV_W = PD_W + 1;
  localparam int DW    = RD_W + 2 * PDV_W;
  localparam int NW    = FREQ_W + FB_W;
  localparam int MW    = FREQ_W + 1 + DW;

  srch_st_e          st_q, st_d;
  logic [FREQ_W-1:0] ref_q, tgt_q, q_best_q;
  pll_set_t          best_q, cand;
  logic              last_pair, last_post;
  logic              it_init, next_pair, next_post, step_post;
  logic              div_start, div_done, exact;
  logic [NW-1:0]     div_quo;
  logic [NW-1:0]     n_prod;
  logic [DW-1:0]     d_prod;
  logic [MW-1:0]     n_ext, over_lim, gain_lim, vco_lo, vco_hi;
  logic              under, better, vco_ok;
  logic [FREQ_W-1:0] req_lim;

  pll_cand_iter #(
    .FB_MIN(FB_MIN), .FB_MAX(FB_MAX), .RD_MIN(RD_MIN), .RD_MAX(RD_MAX)
  ) u_iter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (it_init),
    .next_pair_i(next_pair),
    .next_post_i(next_post),
    .cand_o     (cand),
    .last_pair_o(last_pair),
    .last_post_o(last_post)
  );

  pll_seq_div #(.NW(NW), .DW(DW)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(div_start),
    .num_i  (n_prod),
    .den_i  (d_prod),
    .done_o (div_done),
    .quo_o  (div_quo)
  );

  // candidate numerator and denominator
  assign n_prod = NW'(ref_q) * NW'(cand.fb);
  assign d_prod = DW'(cand.rd) * DW'(PDV_W'(cand.p1) + 1'b1) * DW'(PDV_W'(cand.p2) + 1'b1);
  assign n_ext  = MW'(n_prod);

  // floor(n/d) <= tgt  <=>  n < (tgt+1)*d ; floor(n/d) > best <=> n >= (best+1)*d
  assign over_lim = (MW'(tgt_q) + MW'(1)) * MW'(d_prod);
  assign gain_lim = (MW'(q_best_q) + MW'(1)) * MW'(d_prod);
  assign under    = n_ext < over_lim;
  assign better   = n_ext >= gain_lim;

  assign vco_lo = MW'(VCO_MIN) * MW'(cand.rd);
  assign vco_hi = (MW'(VCO_MAX) + MW'(1)) * MW'(cand.rd);
  assign vco_ok = (n_ext >= vco_lo) && (n_ext < vco_hi);

  assign req_lim = (req_i < OUT_MIN) ? OUT_MIN : ((req_i > OUT_MAX) ? OUT_MAX : req_i);

  assign exact     = div_quo == NW'(tgt_q);
  assign it_init   = (st_q == S_IDLE) && start_i;
  assign div_start = (st_q == S_POST) && under && better;
  assign step_post = ((st_q == S_POST) && !(under && better)) ||
                     ((st_q == S_DIV) && div_done && !exact);
  assign next_post = step_post && !last_post;
  assign next_pair = ((st_q == S_PAIR) && !vco_ok && !last_pair) ||
                     (step_post && last_post && !last_pair);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE: if (start_i) st_d = S_PAIR;
      S_PAIR: begin
        if (vco_ok)         st_d = S_POST;
        else if (last_pair) st_d = S_FIN;
      end
      S_POST: begin
        if (under && better) st_d = S_DIV;
        else if (last_post)  st_d = last_pair ? S_FIN : S_PAIR;
      end
      S_DIV: begin
        if (div_done) begin
          if (exact)          st_d = S_FIN;
          else if (last_post) st_d = last_pair ? S_FIN : S_PAIR;
          else                st_d = S_POST;
        end
      end
      S_FIN:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      ref_q     <= '0;
      tgt_q     <= '0;
      q_best_q  <= '0;
      best_q    <= '0;
      done_o    <= 1'b0;
      setting_o <= '0;
      rate_o    <= '0;
      err_o     <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_o <= 1'b0;
      if (it_init) begin
        ref_q    <= ref_i;
        tgt_q    <= req_lim;
        q_best_q <= '0;
        best_q   <= '0;
      end
      if ((st_q == S_DIV) && div_done) begin
        q_best_q <= div_quo[FREQ_W-1:0];
        best_q   <= cand;
      end
      if (st_q == S_FIN) begin
        done_o <= 1'b1;
        if (q_best_q != '0) begin
          setting_o <= best_q;
          rate_o    <= q_best_q;
          err_o     <= 1'b0;
        end else begin
          setting_o <= '0;
          rate_o    <= '0;
          err_o     <= 1'b1;
        end
      end
    end
  end

  assign busy_o = st_q != S_IDLE;
endmodule

module pll_div_search_chk
  import pll_srch_pkg::*;
#(
  parameter int FREQ_W = 64,
  parameter int FB_MIN = 8,
  parameter int FB_MAX = 1066,
  parameter int RD_MIN = 1,
  parameter int RD_MAX = 63
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [SET_W-1:0]  setting_o,
  input logic [FREQ_W-1:0] rate_o,
  input logic              err_o
);
  pll_set_t s;
  assign s = setting_o;

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R9
  hold_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(setting_o) && $stable(rate_o) && $stable(err_o)));
  // R2
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  // R8
  err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ((setting_o == '0) && (rate_o == '0)));
  // R7
  field_rng_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> ((s.fb >= FB_W'(FB_MIN)) && (s.fb <= FB_W'(FB_MAX)) &&
                            (s.rd >= RD_W'(RD_MIN)) && (s.rd <= RD_W'(RD_MAX))));
  // R3
  rate_nz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (rate_o != '0));
endmodule

bind pll_div_search pll_div_search_chk #(
  .FREQ_W(FREQ_W), .FB_MIN(FB_MIN), .FB_MAX(FB_MAX), .RD_MIN(RD_MIN), .RD_MAX(RD_MAX)
) u_chk (.*);

// File: tb/sim_pll_div_search.sv
module sim_pll_div_search;
  localparam int          FB_MIN = 8;
  localparam int          FB_MAX = 24;
  localparam int          RD_MIN = 1;
  localparam int          RD_MAX = 3;
  localparam longint unsigned VMIN = 1600;
  localparam longint unsigned VMAX = 3200;
  localparam longint unsigned OMIN = 25;
  localparam longint unsigned OMAX = 3200;

  typedef struct {
    logic [23:0] set;
    logic [63:0] rate;
    logic        err;
    longint unsigned rf;
    longint unsigned tgt;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] ref_v = '0;
  logic [63:0] req_v = '0;
  logic        busy, done, err;
  logic [23:0] setting;
  logic [63:0] rate;

  int n_chk = 0;
  int n_fail = 0;
  int hold_bad = 0;
  exp_t sb[$];

  always #10 clk = ~clk;

  pll_div_search #(
    .FREQ_W(64), .FB_MIN(FB_MIN), .FB_MAX(FB_MAX), .RD_MIN(RD_MIN), .RD_MAX(RD_MAX),
    .VCO_MIN(64'(VMIN)), .VCO_MAX(64'(VMAX)), .OUT_MIN(64'(OMIN)), .OUT_MAX(64'(OMAX))
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ref_i(ref_v), .req_i(req_v),
    .busy_o(busy), .done_o(done), .setting_o(setting), .rate_o(rate), .err_o(err)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic exp_t model(input longint unsigned rf, input longint unsigned rq, input string tag);
    exp_t e;
    longint unsigned t, best, r, vco;
    bit hit;
    t = (rq < OMIN) ? OMIN : ((rq > OMAX) ? OMAX : rq);
    best = 0; hit = 0;
    e.set = '0;
    for (int fb = FB_MIN; fb <= FB_MAX; fb++) begin
      if (hit) break;
      for (int rd = RD_MIN; rd <= RD_MAX; rd++) begin
        if (hit) break;
        vco = rf * longint'(fb) / longint'(rd);
        if (vco < VMIN || vco > VMAX) continue;
        for (int p2 = 0; p2 < 8; p2++) begin
          if (hit) break;
          for (int p1 = 0; p1 < 8; p1++) begin
            if (hit) break;
            r = rf * longint'(fb) / longint'(rd * (p1 + 1) * (p2 + 1));
            if (r <= t && r > best) begin
              best = r;
              e.set = {3'(p2), 3'(p1), 6'(rd), 12'(fb)};
              if (r == t) hit = 1;
            end
          end
        end
      end
    end
    e.rate = best;
    e.err  = (best == 0);
    if (e.err) e.set = '0;
    e.rf = rf; e.tgt = t; e.tag = tag;
    return e;
  endfunction

  // monitor / scoreboard
  logic [23:0] last_set;
  logic [63:0] last_rate;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && (setting != last_set || rate != last_rate)) hold_bad++;
      if (!busy) begin last_set = setting; last_rate = rate; end
      if (done) begin
        exp_t e;
        longint unsigned fb, rd, p1, p2, r, vco;
        if (sb.size() == 0) begin
          check(1'b0, "R9 unexpected done", 64'(done), 64'(0));
        end else begin
          e = sb.pop_front();
          check(busy == 1'b0, {e.tag, " R9 busy at done"}, 64'(busy), 64'(0));
          check(err == e.err, {e.tag, " R8 err"}, 64'(err), 64'(e.err));
          check(setting == e.set, {e.tag, " R4 setting"}, 64'(setting), 64'(e.set));
          check(rate == e.rate, {e.tag, " R3 rate"}, rate, e.rate);
          if (!e.err) begin
            // R7 field decode: fb 11:0, rd 17:12, p1 20:18, p2 23:21
            fb = setting[11:0]; rd = setting[17:12]; p1 = setting[20:18]; p2 = setting[23:21];
            r = (rd == 0) ? 0 : e.rf * fb / (rd * (p1 + 1) * (p2 + 1));
            check(r == rate && rate <= e.tgt, {e.tag, " R3 R7 decoded rate"}, rate, r);
            vco = (rd == 0) ? 0 : e.rf * fb / rd;
            check(vco >= VMIN && vco <= VMAX, {e.tag, " R5 vco window"}, vco, VMIN);
          end
        end
      end
    end
  end

  task automatic run(input longint unsigned rf, input longint unsigned rq, input string tag, output int cyc);
    sb.push_back(model(rf, rq, tag));
    @(negedge clk);
    ref_v = rf; req_v = rq; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done) begin @(negedge clk); cyc++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int c_exact, c_near, c;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0 && done == 0 && err == 0, "R1 flags", {61'd0, busy, done, err}, 64'd0);
    check(setting == 0 && rate == 0, "R1 outputs", rate | 64'(setting), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && setting == 0, "R1 after release", 64'(busy), 64'd0);

    run(100, 1000, "R4 R10 exact", c_exact);
    run(100, 999, "R4 near", c_near);
    // R10 early exit shortens the search
    check(c_exact < c_near, "R10 cycles", 64'(c_exact), 64'(c_near));
    run(150, 777, "R4 inexact", c);
    run(100, 0, "R6 low clamp", c);
    run(100, 64'hFFFF_FFFF_FFFF, "R6 high clamp", c);
    run(7, 500, "R8 no vco", c);
    run(70, 1000, "R5 narrow", c);
    run(120, 37, "R4 ties", c);

    // R2 start while busy is ignored
    sb.push_back(model(150, 2000, "R2 busy start"));
    @(negedge clk);
    ref_v = 150; req_v = 2000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy rises", 64'(busy), 64'd1);
    repeat (5) @(negedge clk);
    ref_v = 7; req_v = 30; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 still busy", 64'(busy), 64'd1);
    while (!done) @(negedge clk);
    @(negedge clk);
    check(done == 1'b0, "R9 done one cycle", 64'(done), 64'd0);
    check(sb.size() == 0, "R2 no extra result", 64'(sb.size()), 64'd0);
    check(hold_bad == 0, "R9 hold while busy", 64'(hold_bad), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule